// File: doc/BRIEF.md
# DSP Subsystem Power-Up and Clamp Sequencer

This block is a hardware state machine that takes an embedded DSP subsystem from a cold, clamped state to a fully powered state, and clamps it again before a restart. A single-cycle start request runs a fixed power-up. The strap override is loaded and every rail goes back to its safe value. The core resets are asserted. A crystal-clock branch is enabled and its "clock off" status is polled. The head switch is closed and the LDO is bypassed. The memory clamp is released and the memory periphery is woken. The memory banks are then powered one at a time, and finally the word-line and IO clamps are released. A stop request, accepted only while the sequencer is idle, reasserts the three isolation clamps together and then raises the subsystem restart reset.

Every timed wait comes from one shared down-counter. The parameter `CYCLES_PER_US` sets how many clock cycles make one microsecond. The number of clock-status polls is bounded by `MAX_POLLS`. If the branch never reports that its clock is running, the sequence stops with a sticky error. All outputs are individual control bits and can be wired straight onto the subsystem's power-control and memory-power fields.

Top module: `dsp_power_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs hold their safe values: all three clamps asserted, head switch, LDO bypass, clock branch enable, standby-n, retention-n and every memory bank off, the three core reset controls and the restart reset asserted, strap output 0, and busy, done and error low.
- R2: A start sampled while idle is accepted. If start and stop arrive together, start wins. The first step puts every rail back to its safe value, releases the restart reset and drives the strap output to 0x20. The strap value is already present in the first cycle the clock branch enable is high.
- R3: The clock-off input is sampled at the end of cycle CYCLES_PER_US-1+j*CYCLES_PER_US, for j = 0 .. MAX_POLLS-1, counted from the first cycle the branch enable is high. The first sample that reads 0 closes the head switch 2 cycles later. If all MAX_POLLS samples read 1, error rises in cycle MAX_POLLS*CYCLES_PER_US, busy drops, and the head switch stays open.
- R4: LDO bypass turns on exactly CYCLES_PER_US+1 cycles after the head switch closes.
- R5: The memory compiler clamp is released 1 cycle after LDO bypass turns on. L2 standby-n and retention-n both go high 1 cycle after that.
- R6: Memory banks turn on one bank per step, highest index first, and each bank stays on. The first bank turns on 1 cycle after retention-n rises, and each later bank CYCLES_PER_US+1 cycles after the previous one.
- R7: The word-line clamp is released CYCLES_PER_US+1 cycles after bank 0 turns on, and only once all banks are on. The IO clamp is released 1 cycle after the word-line clamp.
- R8: A stop sampled while idle asserts the IO, word-line and memory compiler clamps together 2 cycles later. The restart reset rises 1 cycle after the clamps.
- R9: done is a one-cycle pulse in the cycle the IO clamp is released, and busy is low in that cycle. Busy is high from the cycle after an accepted start until then.
- R10: Start and stop requests sampled while busy have no effect. The running sequence completes with exactly one done pulse, and the clamps and restart reset end unchanged by the ignored stop.
- R11: Error stays high until the next accepted start and is low in the cycle after that start is sampled.
- R12: Core reset, bus reset enable and core stop stay asserted throughout power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Power-up request, sampled each cycle |
| stopReq | input | 1 | Clamp-and-restart request, sampled each cycle |
| xtalBranchOff | input | 1 | Clock branch status, 1 = clock not yet running |
| strapOvr | output | STRAP_W | Access strap override value |
| rstCore | output | 1 | Core reset, 1 = asserted |
| rstBusEn | output | 1 | Bus reset enable, 1 = asserted |
| haltCore | output | 1 | Core stop control, 1 = stopped |
| xtalBranchEn | output | 1 | Crystal clock branch enable |
| headSwitchEn | output | 1 | Block head switch enable |
| regBypass | output | 1 | LDO bypass |
| clampCompMem | output | 1 | Memory compiler clamp, 1 = clamped |
| clampWordLine | output | 1 | Word-line clamp, 1 = clamped |
| clampIo | output | 1 | IO clamp, 1 = clamped |
| l2StandbyN | output | 1 | L2 data standby, active low |
| retainN | output | 1 | Memory sleep retention, active low |
| memBankOn | output | MEM_BANKS | Per-bank power enable |
| subsysRestart | output | 1 | Subsystem restart reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-power-up pulse |
| error | output | 1 | Sticky clock-branch timeout |

## Verification
The hardest situation to reach is the exact edge of the poll budget. This is the case where the clock-off status clears just in time for the last allowed sample, or one cycle too late to count. The bench models the clock branch: it drops the off status a chosen number of cycles after it sees the branch enable. Two directed runs place that drop at MAX_POLLS*CYCLES_PER_US-1 cycles, which still succeeds, and at MAX_POLLS*CYCLES_PER_US cycles, which times out. Random runs spread the drop across the whole window while stray start and stop pulses arrive mid-sequence.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_STRAP,
    S_RESETS,
    S_XO_EN,
    S_XO_POLL,
    S_HS_ON,
    S_HS_WAIT,
    S_LDO,
    S_QMC,
    S_MEM_WAKE,
    S_MEM_STEP,
    S_MEM_WAIT,
    S_WL,
    S_IO,
    S_DONE,
    S_STOP_CLAMP,
    S_STOP_RST
  } seq_state_t;

  // One-cycle commands from the controller to the datapath
  typedef struct packed {
    logic loadStrap;
    logic safeAll;
    logic assertRst;
    logic xoOn;
    logic loadWait;
    logic pollClr;
    logic pollInc;
    logic hsOn;
    logic ldoOn;
    logic qmcOff;
    logic memWake;
    logic memStep;
    logic wlOff;
    logic ioOff;
    logic clampAll;
    logic restartOn;
  } seq_strobe_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        xtalBranchOff,
  input  logic        waitDone,
  input  logic        pollLast,
  input  logic        memAllOn,
  output seq_strobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        error
);

  seq_state_t state, nextState;
  logic errSet, errClr;

  always_comb begin
    nextState = state;
    stb       = '0;
    errSet    = 1'b0;
    errClr    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          nextState = S_STRAP;
          errClr    = 1'b1;
        end else if (stopReq) begin
          nextState = S_STOP_CLAMP;
        end
      end
      S_STRAP: begin
        stb.loadStrap = 1'b1;
        stb.safeAll   = 1'b1;
        nextState     = S_RESETS;
      end
      S_RESETS: begin
        stb.assertRst = 1'b1;
        nextState     = S_XO_EN;
      end
      S_XO_EN: begin
        stb.xoOn     = 1'b1;
        stb.loadWait = 1'b1;
        stb.pollClr  = 1'b1;
        nextState    = S_XO_POLL;
      end
      S_XO_POLL: begin
        if (waitDone) begin
          if (!xtalBranchOff) begin
            nextState = S_HS_ON;
          end else if (pollLast) begin
            nextState = S_IDLE;
            errSet    = 1'b1;
          end else begin
            stb.pollInc  = 1'b1;
            stb.loadWait = 1'b1;
          end
        end
      end
      S_HS_ON: begin
        stb.hsOn     = 1'b1;
        stb.loadWait = 1'b1;
        nextState    = S_HS_WAIT;
      end
      S_HS_WAIT: begin
        if (waitDone) nextState = S_LDO;
      end
      S_LDO: begin
        stb.ldoOn = 1'b1;
        nextState = S_QMC;
      end
      S_QMC: begin
        stb.qmcOff = 1'b1;
        nextState  = S_MEM_WAKE;
      end
      S_MEM_WAKE: begin
        stb.memWake = 1'b1;
        nextState   = S_MEM_STEP;
      end
      S_MEM_STEP: begin
        stb.memStep  = 1'b1;
        stb.loadWait = 1'b1;
        nextState    = S_MEM_WAIT;
      end
      S_MEM_WAIT: begin
        if (waitDone) nextState = memAllOn ? S_WL : S_MEM_STEP;
      end
      S_WL: begin
        stb.wlOff = 1'b1;
        nextState = S_IO;
      end
      S_IO: begin
        stb.ioOff = 1'b1;
        nextState = S_DONE;
      end
      S_DONE: nextState = S_IDLE;
      S_STOP_CLAMP: begin
        stb.clampAll = 1'b1;
        nextState    = S_STOP_RST;
      end
      S_STOP_RST: begin
        stb.restartOn = 1'b1;
        nextState     = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      error <= 1'b0;
    end else begin
      state <= nextState;
      if (errSet)      error <= 1'b1;
      else if (errClr) error <= 1'b0;
    end
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  // R9: done never lasts two cycles
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: an error is only ever reported while the sequencer is not running
  p_error_idle_r11: assert property (@(posedge clk) disable iff (rst)
    error |-> !busy);

  // R8: the clamp step is always followed by the restart step
  p_stop_order_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_STOP_CLAMP) |=> (state == S_STOP_RST));

endmodule

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int CYCLES_PER_US = 4,
  parameter int MAX_POLLS     = 200,
  parameter int MEM_BANKS     = 20,
  parameter int STRAP_W       = 8,
  parameter logic [STRAP_W-1:0] STRAP_VALUE = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seq_strobe_t          stb,
  output logic                 waitDone,
  output logic                 pollLast,
  output logic                 memAllOn,
  output logic [STRAP_W-1:0]   strapOvr,
  output logic                 rstCore,
  output logic                 rstBusEn,
  output logic                 haltCore,
  output logic                 xtalBranchEn,
  output logic                 headSwitchEn,
  output logic                 regBypass,
  output logic                 clampCompMem,
  output logic                 clampWordLine,
  output logic                 clampIo,
  output logic                 l2StandbyN,
  output logic                 retainN,
  output logic [MEM_BANKS-1:0] memBankOn,
  output logic                 subsysRestart
);

  localparam int WAIT_W = $clog2(CYCLES_PER_US + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int BANK_W = (MEM_BANKS > 1) ? $clog2(MEM_BANKS) : 1;
  localparam logic [WAIT_W-1:0] WAIT_RELOAD = WAIT_W'(CYCLES_PER_US - 1);
  localparam logic [POLL_W-1:0] POLL_FINAL  = POLL_W'(MAX_POLLS - 1);
  localparam logic [BANK_W-1:0] BANK_TOP    = BANK_W'(MEM_BANKS - 1);

  logic [WAIT_W-1:0]    waitCnt;
  logic [POLL_W-1:0]    pollCnt;
  logic [BANK_W-1:0]    bankIdx;
  logic [MEM_BANKS-1:0] bankHit;

  // Shared microsecond timer
  always_ff @(posedge clk) begin
    if (rst)                waitCnt <= '0;
    else if (stb.loadWait)  waitCnt <= WAIT_RELOAD;
    else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  // Clock branch poll counter
  always_ff @(posedge clk) begin
    if (rst || stb.pollClr) pollCnt <= '0;
    else if (stb.pollInc)   pollCnt <= pollCnt + 1'b1;
  end
  assign pollLast = (pollCnt == POLL_FINAL);

  // Bank pointer, walks from the top bank down to bank 0
  always_ff @(posedge clk) begin
    if (rst || stb.safeAll) bankIdx <= BANK_TOP;
    else if (stb.memStep && bankIdx != '0) bankIdx <= bankIdx - 1'b1;
  end

  for (genvar b = 0; b < MEM_BANKS; b++) begin : g_bankHit
    assign bankHit[b] = stb.memStep && (bankIdx == BANK_W'(b));
  end

  always_ff @(posedge clk) begin
    if (rst || stb.safeAll) memBankOn <= '0;
    else                    memBankOn <= memBankOn | bankHit;
  end
  assign memAllOn = &memBankOn;

  // Rail and clamp control bits
  always_ff @(posedge clk) begin
    if (rst) begin
      strapOvr      <= '0;
      rstCore       <= 1'b1;
      rstBusEn      <= 1'b1;
      haltCore      <= 1'b1;
      xtalBranchEn  <= 1'b0;
      headSwitchEn  <= 1'b0;
      regBypass     <= 1'b0;
      clampCompMem  <= 1'b1;
      clampWordLine <= 1'b1;
      clampIo       <= 1'b1;
      l2StandbyN    <= 1'b0;
      retainN       <= 1'b0;
      subsysRestart <= 1'b1;
    end else begin
      if (stb.safeAll) begin
        rstCore       <= 1'b1;
        rstBusEn      <= 1'b1;
        haltCore      <= 1'b1;
        xtalBranchEn  <= 1'b0;
        headSwitchEn  <= 1'b0;
        regBypass     <= 1'b0;
        clampCompMem  <= 1'b1;
        clampWordLine <= 1'b1;
        clampIo       <= 1'b1;
        l2StandbyN    <= 1'b0;
        retainN       <= 1'b0;
        subsysRestart <= 1'b0;
      end
      if (stb.loadStrap) strapOvr <= STRAP_VALUE;
      if (stb.assertRst) begin
        rstCore  <= 1'b1;
        rstBusEn <= 1'b1;
        haltCore <= 1'b1;
      end
      if (stb.xoOn)    xtalBranchEn  <= 1'b1;
      if (stb.hsOn)    headSwitchEn  <= 1'b1;
      if (stb.ldoOn)   regBypass     <= 1'b1;
      if (stb.qmcOff)  clampCompMem  <= 1'b0;
      if (stb.memWake) begin
        l2StandbyN <= 1'b1;
        retainN    <= 1'b1;
      end
      if (stb.wlOff)   clampWordLine <= 1'b0;
      if (stb.ioOff)   clampIo       <= 1'b0;
      if (stb.clampAll) begin
        clampIo       <= 1'b1;
        clampWordLine <= 1'b1;
        clampCompMem  <= 1'b1;
      end
      if (stb.restartOn) subsysRestart <= 1'b1;
    end
  end

  // R3: the poll budget is never overrun
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pollCnt < POLL_W'(MAX_POLLS));

  // R4: LDO bypass only with the head switch closed
  p_ldo_after_hs_r4: assert property (@(posedge clk) disable iff (rst)
    regBypass |-> headSwitchEn);

  // R5: compiler clamp only released once the LDO is bypassed
  p_qmc_after_ldo_r5: assert property (@(posedge clk) disable iff (rst)
    !clampCompMem |-> regBypass);

  // R6: at most one bank turns on per cycle
  p_one_bank_r6: assert property (@(posedge clk) disable iff (rst)
    (memBankOn != $past(memBankOn) && memBankOn != '0)
      |-> ($countones(memBankOn ^ $past(memBankOn)) == 1));

  // R7: word-line clamp released only with all banks on
  p_wl_after_mem_r7: assert property (@(posedge clk) disable iff (rst)
    !clampWordLine |-> memAllOn);

  // R7: IO clamp released only after the word-line clamp
  p_io_after_wl_r7: assert property (@(posedge clk) disable iff (rst)
    !clampIo |-> !clampWordLine);

  // R8: restart reset rises only with every clamp in place
  p_restart_clamped_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(subsysRestart) |-> (clampIo && clampWordLine && clampCompMem));

endmodule

// File: rtl/dsp_power_sequencer.sv
module dsp_power_sequencer
  import pwrseq_pkg::*;
#(
  parameter int CYCLES_PER_US = 4,
  parameter int MAX_POLLS     = 200,
  parameter int MEM_BANKS     = 20,
  parameter int STRAP_W       = 8,
  parameter logic [STRAP_W-1:0] STRAP_VALUE = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startReq,
  input  logic                 stopReq,
  input  logic                 xtalBranchOff,
  output logic [STRAP_W-1:0]   strapOvr,
  output logic                 rstCore,
  output logic                 rstBusEn,
  output logic                 haltCore,
  output logic                 xtalBranchEn,
  output logic                 headSwitchEn,
  output logic                 regBypass,
  output logic                 clampCompMem,
  output logic                 clampWordLine,
  output logic                 clampIo,
  output logic                 l2StandbyN,
  output logic                 retainN,
  output logic [MEM_BANKS-1:0] memBankOn,
  output logic                 subsysRestart,
  output logic                 busy,
  output logic                 done,
  output logic                 error
);

  seq_strobe_t stb;
  logic waitDone, pollLast, memAllOn;

  pwrseq_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .startReq      (startReq),
    .stopReq       (stopReq),
    .xtalBranchOff (xtalBranchOff),
    .waitDone      (waitDone),
    .pollLast      (pollLast),
    .memAllOn      (memAllOn),
    .stb           (stb),
    .busy          (busy),
    .done          (done),
    .error         (error)
  );

  pwrseq_datapath #(
    .CYCLES_PER_US (CYCLES_PER_US),
    .MAX_POLLS     (MAX_POLLS),
    .MEM_BANKS     (MEM_BANKS),
    .STRAP_W       (STRAP_W),
    .STRAP_VALUE   (STRAP_VALUE)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .stb           (stb),
    .waitDone      (waitDone),
    .pollLast      (pollLast),
    .memAllOn      (memAllOn),
    .strapOvr      (strapOvr),
    .rstCore       (rstCore),
    .rstBusEn      (rstBusEn),
    .haltCore      (haltCore),
    .xtalBranchEn  (xtalBranchEn),
    .headSwitchEn  (headSwitchEn),
    .regBypass     (regBypass),
    .clampCompMem  (clampCompMem),
    .clampWordLine (clampWordLine),
    .clampIo       (clampIo),
    .l2StandbyN    (l2StandbyN),
    .retainN       (retainN),
    .memBankOn     (memBankOn),
    .subsysRestart (subsysRestart)
  );

  // R12: core held in reset whenever the sequence runs
  p_resets_held_r12: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rstCore && rstBusEn && haltCore));

  // R2: the clock branch is never enabled without the strap value in place
  p_strap_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(xtalBranchEn) |-> (strapOvr == STRAP_VALUE));

endmodule

// File: tb/tb_dsp_power_sequencer.sv
module tb_dsp_power_sequencer;

  localparam int CPU   = 4;
  localparam int MAXP  = 200;
  localparam int NB    = 20;
  localparam int LIMIT = MAXP * CPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic taskStart = 1'b0, taskStop = 1'b0;
  logic injStart = 1'b0, injStop = 1'b0;
  logic offDrop = 1'b0;
  logic startReq, stopReq, xtalBranchOff;
  logic [7:0] strapOvr;
  logic rstCore, rstBusEn, haltCore, xtalBranchEn, headSwitchEn, regBypass;
  logic clampCompMem, clampWordLine, clampIo, l2StandbyN, retainN;
  logic [NB-1:0] memBankOn;
  logic subsysRestart, busy, done, error;

  assign startReq      = taskStart | injStart;
  assign stopReq       = taskStop | injStop;
  assign xtalBranchOff = !offDrop;

  always #2.5 clk = ~clk;

  dsp_power_sequencer #(
    .CYCLES_PER_US (CPU),
    .MAX_POLLS     (MAXP),
    .MEM_BANKS     (NB),
    .STRAP_W       (8),
    .STRAP_VALUE   (8'h20)
  ) dut (
    .clk (clk), .rst (rst), .startReq (startReq), .stopReq (stopReq),
    .xtalBranchOff (xtalBranchOff), .strapOvr (strapOvr), .rstCore (rstCore),
    .rstBusEn (rstBusEn), .haltCore (haltCore), .xtalBranchEn (xtalBranchEn),
    .headSwitchEn (headSwitchEn), .regBypass (regBypass),
    .clampCompMem (clampCompMem), .clampWordLine (clampWordLine),
    .clampIo (clampIo), .l2StandbyN (l2StandbyN), .retainN (retainN),
    .memBankOn (memBankOn), .subsysRestart (subsysRestart),
    .busy (busy), .done (done), .error (error)
  );

  int checks = 0;
  int errs   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle of the first successful poll, plus two, counted from enable
  function automatic int expHsOffset(input int k);
    int p = CPU - 1;
    while (p < k) p += CPU;
    return p + 2;
  endfunction

  // Monitor and clock branch model, sampled away from the active edge
  int cyc = 0, tXo = 0, tHs = 0, tLdo = 0, tQmc = 0, tSlp = 0;
  int tMem = 0, tWl = 0, tIo = 0;
  int nextIdx = NB - 1;
  int doneCnt = 0, errCnt = 0;
  int kVal = 0;
  bit injEn = 1'b0;
  logic pXo = 0, pHs = 0, pLdo = 0, pQmc = 1, pSlp = 0, pWl = 1, pIo = 1;
  logic pDone = 0, pErr = 0;
  logic [NB-1:0] pMem = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (xtalBranchEn && !pXo) begin
        tXo = cyc;
        chk(strapOvr == 8'h20, "R2", "strap at branch enable", strapOvr, 32);
        chk(rstCore && rstBusEn && haltCore, "R12", "resets at branch enable",
            {rstCore, rstBusEn, haltCore}, 7);
      end
      if (!xtalBranchEn) offDrop = 1'b0;
      else if (cyc - tXo >= kVal) offDrop = 1'b1;

      if (headSwitchEn && !pHs) begin
        tHs = cyc;
        chk(cyc - tXo == expHsOffset(kVal), "R3", "head switch offset",
            cyc - tXo, expHsOffset(kVal));
      end
      if (regBypass && !pLdo) begin
        tLdo = cyc;
        chk(cyc - tHs == CPU + 1, "R4", "ldo bypass gap", cyc - tHs, CPU + 1);
      end
      if (!clampCompMem && pQmc) begin
        tQmc = cyc;
        chk(cyc - tLdo == 1, "R5", "compiler clamp gap", cyc - tLdo, 1);
      end
      if (l2StandbyN && !pSlp) begin
        tSlp = cyc;
        chk(retainN && (cyc - tQmc == 1), "R5", "standby/retention gap",
            cyc - tQmc, 1);
      end
      if (memBankOn == '0 && pMem != '0) nextIdx = NB - 1;
      if (memBankOn != pMem && memBankOn != '0) begin
        logic [NB-1:0] expMem;
        expMem = pMem | (NB'(1) << nextIdx);
        chk(memBankOn == expMem, "R6", "bank pattern", memBankOn, expMem);
        if (nextIdx == NB - 1)
          chk(cyc - tSlp == 1, "R6", "first bank gap", cyc - tSlp, 1);
        else
          chk(cyc - tMem == CPU + 1, "R6", "bank step gap", cyc - tMem, CPU + 1);
        tMem = cyc;
        if (nextIdx > 0) nextIdx--;
      end
      if (!clampWordLine && pWl) begin
        tWl = cyc;
        chk((&memBankOn) && (cyc - tMem == CPU + 1), "R7", "word-line release gap",
            cyc - tMem, CPU + 1);
      end
      if (!clampIo && pIo) begin
        tIo = cyc;
        chk(cyc - tWl == 1, "R7", "io release gap", cyc - tWl, 1);
      end
      if (done) begin
        doneCnt++;
        chk(cyc == tIo && !busy, "R9", "done cycle vs io release", cyc, tIo);
        chk(!pDone, "R9", "done pulse width", pDone, 0);
      end
      if (error && !pErr) begin
        errCnt++;
        chk(cyc - tXo == LIMIT, "R3", "timeout cycle", cyc - tXo, LIMIT);
      end
      injStart = injEn && busy && ($urandom_range(0, 29) == 0);
      injStop  = injEn && busy && ($urandom_range(0, 29) == 0);
    end
    pXo = xtalBranchEn; pHs = headSwitchEn; pLdo = regBypass; pQmc = clampCompMem;
    pSlp = l2StandbyN; pWl = clampWordLine; pIo = clampIo; pMem = memBankOn;
    pDone = done; pErr = error;
  end

  task automatic runSeq(input int k, input bit inj);
    int d0, e0, n;
    bit ok;
    kVal = k;
    d0 = doneCnt; e0 = errCnt;
    @(negedge clk); taskStart = 1'b1;
    @(negedge clk); taskStart = 1'b0;
    chk(!error && busy, "R11", "error cleared by start", error, 0);
    injEn = inj;
    n = 0;
    while (doneCnt == d0 && errCnt == e0 && n < 4000) begin
      @(negedge clk); n++;
    end
    injEn = 1'b0;
    ok = (k < LIMIT);
    repeat (3) @(negedge clk);
    chk((doneCnt - d0) == (ok ? 1 : 0), "R10", "done pulses per run",
        doneCnt - d0, ok ? 1 : 0);
    chk((errCnt - e0) == (ok ? 0 : 1), "R3", "timeouts per run",
        errCnt - e0, ok ? 0 : 1);
    if (ok) begin
      chk(&memBankOn, "R6", "all banks on", memBankOn, {NB{1'b1}});
      chk(!clampIo && !clampWordLine && !clampCompMem && !subsysRestart,
          "R10", "clamps/restart after run",
          {clampIo, clampWordLine, clampCompMem, subsysRestart}, 0);
      chk(!busy && !error, "R9", "idle after done", {busy, error}, 0);
    end else begin
      chk(error && !busy && !headSwitchEn && memBankOn == '0, "R3",
          "state after timeout", {error, busy, headSwitchEn}, 4);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk(clampIo && clampWordLine && clampCompMem && !headSwitchEn && !regBypass
        && !xtalBranchEn && memBankOn == '0 && subsysRestart && rstCore
        && rstBusEn && haltCore && strapOvr == 0 && !busy && !done && !error
        && !l2StandbyN && !retainN, "R1", "safe values in reset", 0, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(clampIo && !headSwitchEn && memBankOn == '0 && subsysRestart && !busy,
        "R1", "safe values after reset", {clampIo, headSwitchEn, busy}, 4);

    // R2/R3: clock already running, then exact budget edges
    runSeq(0, 1'b0);
    runSeq(LIMIT - 1, 1'b0);
    runSeq(LIMIT, 1'b0);
    // R11: error is sticky while idle
    repeat (20) @(negedge clk);
    chk(error && !busy, "R11", "error held while idle", error, 1);
    runSeq(7, 1'b0);

    // R8: stop while idle
    @(negedge clk); taskStop = 1'b1;
    @(negedge clk); taskStop = 1'b0;
    chk(!clampIo && !subsysRestart, "R8", "clamps one cycle after stop", clampIo, 0);
    @(negedge clk);
    chk(clampIo && clampWordLine && clampCompMem && !subsysRestart, "R8",
        "clamps together", {clampIo, clampWordLine, clampCompMem, subsysRestart}, 14);
    @(negedge clk);
    chk(subsysRestart && !busy, "R8", "restart after clamps", subsysRestart, 1);

    // R2: start and stop together, start wins
    @(negedge clk); taskStart = 1'b1; taskStop = 1'b1;
    @(negedge clk); taskStart = 1'b0; taskStop = 1'b0;
    chk(busy, "R2", "start wins over stop", busy, 1);
    repeat (2) @(negedge clk);
    chk(!subsysRestart && strapOvr == 8'h20, "R2", "restart released, strap loaded",
        subsysRestart, 0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    // R10: random drops with stray requests mid-sequence
    for (int i = 0; i < 12; i++) begin
      int k;
      k = (i % 4 == 3) ? LIMIT + $urandom_range(0, CPU)
                       : $urandom_range(0, LIMIT - 1);
      runSeq(k, 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule